// File: doc/BRIEF.md
# Circuit-Switched Mesh Tile Switch

This block is the communication switch of one tile in a two-dimensional mesh of small processors. Eight incoming links arrive from the neighbouring tiles, and eight outgoing links leave toward them. Each link moves one 16-bit word per clock, with a valid strobe. Software sets a static route for every outgoing link. The link is driven either by the local core's output word or by one of the eight incoming links. Long-distance traffic can therefore cross the tile without the core taking part. Every outgoing route can add one register stage, so that long paths can be cut into shorter timing segments.

Two configuration registers choose which incoming links feed the core. Each chosen link fills its own 64-word, 16-bit FIFO, and the core drains that FIFO. When a FIFO is full, the switch lowers the ready signal of the incoming link that feeds it, so that the sending tile holds its data. A configuration write is accepted only while the path it would change is idle. A route therefore never switches while a word is in flight on it. The whole switch runs on one clock.

Top module: `tileRouter`

## Requirements
- R1: After reset every outgoing valid is low and its data is zero, both core read valids are low, and every incoming ready is high. Every outgoing route starts out disabled.
- R2: A write to configuration address 0 to 7 sets the outgoing link with that index. Data bits [3:0] give the route and bit 4 gives the pipeline enable. Route 0 drives the link from the core's word and valid in the same cycle. Whenever an outgoing valid is low, its data reads zero.
- R3: Route values 1 to 8 drive the outgoing link from incoming link (route − 1) in the same cycle. Route values 9 to 15 disable the outgoing link, so its valid is low and its data is zero.
- R4: When the pipeline enable of an outgoing link is set, the link shows the valid and data of its source one clock later.
- R5: Configuration addresses 8 and 9 set core input 0 and core input 1. Data bits [2:0] pick the incoming link and bit 3 enables the input. While an input is enabled, every cycle in which the chosen link is valid and the FIFO is not full writes that word into the FIFO. A disabled input writes nothing. Writes to addresses 10 to 15 have no effect.
- R6: Each core FIFO holds 64 words. A word written at a clock edge becomes visible after that edge: read valid goes high and the read data shows the oldest word. A read strobe while read valid is high removes the oldest word. Words leave in the order they arrived.
- R7: An incoming link's ready is low exactly when an enabled core input has chosen that link and the input's FIFO holds 64 words. A word offered in that state is not stored. All other incoming links show ready high.
- R8: A write to an outgoing link's configuration is ignored in any cycle in which that link is busy. The link is busy when its current source is valid, or when its pipeline stage holds a valid word.
- R9: A write to a core input's configuration is ignored in any cycle in which that input is enabled and its chosen link's valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switch clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register index |
| cfgData | input | 5 | Configuration write value |
| inData | input | 128 | Eight incoming words, link k at bits [16k+15:16k] |
| inValid | input | 8 | Incoming word valid, one bit per link |
| inReady | output | 8 | Incoming link may send, one bit per link |
| coreOutData | input | 16 | Word from the local core |
| coreOutValid | input | 1 | Core word valid |
| outData | output | 128 | Eight outgoing words, link i at bits [16i+15:16i] |
| outValid | output | 8 | Outgoing word valid, one bit per link |
| coreRdEn | input | 2 | Core read strobe for each input FIFO |
| coreRdData | output | 32 | Oldest word of each FIFO, FIFO j at bits [16j+15:16j] |
| coreRdValid | output | 2 | FIFO holds at least one word |

## Verification
The bench targets the following corner cases:

- **Writes while a path is busy.** A write is attempted while a source word is present, and again while a word is held only in a pipeline stage. A design that accepts either write would re-route mid-flight. The link would then take data from the new source one cycle early, or it would drop the held word.
- **Filling a FIFO past capacity.** Seventy words are offered into a 64-word FIFO. A design with an off-by-one full flag would let a 65th word overwrite the oldest entry, or it would lower ready one word early.
- **Input selection.** The bench checks that ready falls only on the chosen link, and that a disabled input stores nothing.
- **Random traffic.** Long random runs mix traffic, reads and configuration writes to every address, including the unused ones. A wrong route, a missing stage delay, or stale data left in a pipeline register after a route change shows up as a per-cycle mismatch against the reference model.

// File: rtl/tileRouterPkg.sv
package tileRouterPkg;
  localparam int LINKS   = 8;
  localparam int DATA_W  = 16;
  localparam int CORE_IN = 2;
  localparam int OSEL_W  = 4;
  localparam int ISEL_W  = $clog2(LINKS);
  localparam int CFG_AW  = 4;
  localparam int CFG_DW  = OSEL_W + 1;

  localparam logic [OSEL_W-1:0] SEL_CORE = '0;
  localparam logic [OSEL_W-1:0] SEL_OFF  = '1;

  // Static routing state handed from control to datapath
  typedef struct packed {
    logic [LINKS-1:0][OSEL_W-1:0]   outSel;
    logic [LINKS-1:0]               outPipe;
    logic [CORE_IN-1:0][ISEL_W-1:0] inSel;
    logic [CORE_IN-1:0]             inEn;
  } ctrlBus_t;
endpackage

// File: rtl/tileRouterCtrl.sv
module tileRouterCtrl
  import tileRouterPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [CFG_DW-1:0]  cfgData,
  input  logic [LINKS-1:0]   outBusy,
  input  logic [CORE_IN-1:0] inBusy,
  output ctrlBus_t           cfg
);
  // A write lands only when the path it would change carries nothing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINKS; i++) begin
        cfg.outSel[i]  <= SEL_OFF;
        cfg.outPipe[i] <= 1'b0;
      end
      for (int j = 0; j < CORE_IN; j++) begin
        cfg.inSel[j] <= '0;
        cfg.inEn[j]  <= 1'b0;
      end
    end else if (cfgWrEn) begin
      for (int i = 0; i < LINKS; i++) begin
        if (cfgAddr == CFG_AW'(i) && !outBusy[i]) begin
          cfg.outSel[i]  <= cfgData[OSEL_W-1:0];
          cfg.outPipe[i] <= cfgData[OSEL_W];
        end
      end
      for (int j = 0; j < CORE_IN; j++) begin
        if (cfgAddr == CFG_AW'(LINKS + j) && !inBusy[j]) begin
          cfg.inSel[j] <= cfgData[ISEL_W-1:0];
          cfg.inEn[j]  <= cfgData[ISEL_W];
        end
      end
    end
  end
endmodule

// File: rtl/tileRouterFifo.sv
module tileRouterFifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       rdEn,
  output logic [DATA_W-1:0]          rdData,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic              pop;

  assign pop    = rdEn && (count != '0);
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({wrEn, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tileRouterPath.sv
module tileRouterPath
  import tileRouterPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlBus_t                   cfg,
  input  logic [LINKS*DATA_W-1:0]    inData,
  input  logic [LINKS-1:0]           inValid,
  output logic [LINKS-1:0]           inReady,
  input  logic [DATA_W-1:0]          coreOutData,
  input  logic                       coreOutValid,
  output logic [LINKS*DATA_W-1:0]    outData,
  output logic [LINKS-1:0]           outValid,
  output logic [LINKS-1:0]           outBusy,
  input  logic [CORE_IN-1:0]         fifoFull,
  output logic [CORE_IN-1:0]         fifoWr,
  output logic [CORE_IN*DATA_W-1:0]  fifoWrData,
  output logic [CORE_IN-1:0]         inBusy
);
  // Outgoing routes
  for (genvar i = 0; i < LINKS; i++) begin : gOut
    logic              srcV, pipeV, selV;
    logic [DATA_W-1:0] srcD, pipeD, selD;

    always_comb begin
      srcV = 1'b0;
      srcD = '0;
      if (cfg.outSel[i] == SEL_CORE) begin
        srcV = coreOutValid;
        srcD = coreOutData;
      end else begin
        for (int k = 0; k < LINKS; k++) begin
          if (cfg.outSel[i] == OSEL_W'(k + 1)) begin
            srcV = inValid[k];
            srcD = inData[k*DATA_W +: DATA_W];
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipeV <= 1'b0;
        pipeD <= '0;
      end else begin
        pipeV <= srcV;
        pipeD <= srcD;
      end
    end

    assign selV = cfg.outPipe[i] ? pipeV : srcV;
    assign selD = cfg.outPipe[i] ? pipeD : srcD;
    assign outValid[i]                  = selV;
    assign outData[i*DATA_W +: DATA_W]  = selV ? selD : '0;
    assign outBusy[i]                   = srcV || (cfg.outPipe[i] && pipeV);
  end

  // Core input selection
  for (genvar j = 0; j < CORE_IN; j++) begin : gIn
    logic              pickV;
    logic [DATA_W-1:0] pickD;

    always_comb begin
      pickV = 1'b0;
      pickD = '0;
      for (int k = 0; k < LINKS; k++) begin
        if (cfg.inSel[j] == ISEL_W'(k)) begin
          pickV = inValid[k];
          pickD = inData[k*DATA_W +: DATA_W];
        end
      end
    end

    assign inBusy[j]                       = cfg.inEn[j] && pickV;
    assign fifoWr[j]                       = cfg.inEn[j] && pickV && !fifoFull[j];
    assign fifoWrData[j*DATA_W +: DATA_W]  = pickD;
  end

  // Backpressure onto the chosen links
  always_comb begin
    inReady = '1;
    for (int j = 0; j < CORE_IN; j++) begin
      for (int k = 0; k < LINKS; k++) begin
        if (cfg.inEn[j] && cfg.inSel[j] == ISEL_W'(k) && fifoFull[j]) inReady[k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tileRouter.sv
module tileRouter
  import tileRouterPkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [CFG_AW-1:0]         cfgAddr,
  input  logic [CFG_DW-1:0]         cfgData,
  input  logic [LINKS*DATA_W-1:0]   inData,
  input  logic [LINKS-1:0]          inValid,
  output logic [LINKS-1:0]          inReady,
  input  logic [DATA_W-1:0]         coreOutData,
  input  logic                      coreOutValid,
  output logic [LINKS*DATA_W-1:0]   outData,
  output logic [LINKS-1:0]          outValid,
  input  logic [CORE_IN-1:0]        coreRdEn,
  output logic [CORE_IN*DATA_W-1:0] coreRdData,
  output logic [CORE_IN-1:0]        coreRdValid
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  ctrlBus_t                        cfg;
  logic [LINKS-1:0]                outBusy;
  logic [CORE_IN-1:0]              inBusy, fifoFull, fifoWr;
  logic [CORE_IN*DATA_W-1:0]       fifoWrData;
  logic [CORE_IN-1:0][CW-1:0]      fifoCount;

  tileRouterCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .outBusy(outBusy), .inBusy(inBusy), .cfg(cfg)
  );

  tileRouterPath u_path (
    .clk(clk), .rstN(rstN), .cfg(cfg), .inData(inData), .inValid(inValid),
    .inReady(inReady), .coreOutData(coreOutData), .coreOutValid(coreOutValid),
    .outData(outData), .outValid(outValid), .outBusy(outBusy),
    .fifoFull(fifoFull), .fifoWr(fifoWr), .fifoWrData(fifoWrData), .inBusy(inBusy)
  );

  for (genvar j = 0; j < CORE_IN; j++) begin : gFifo
    tileRouterFifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rstN(rstN), .wrEn(fifoWr[j]),
      .wrData(fifoWrData[j*DATA_W +: DATA_W]), .rdEn(coreRdEn[j]),
      .rdData(coreRdData[j*DATA_W +: DATA_W]), .count(fifoCount[j])
    );
    assign fifoFull[j]    = (fifoCount[j] == CW'(FIFO_DEPTH));
    assign coreRdValid[j] = (fifoCount[j] != '0);
  end
endmodule

// File: rtl/tileRouterChk.sv
module tileRouterChk
  import tileRouterPkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input logic                                      clk,
  input logic                                      rstN,
  input ctrlBus_t                                  cfg,
  input logic [LINKS-1:0]                          inReady,
  input logic                                      coreOutValid,
  input logic [LINKS*DATA_W-1:0]                   outData,
  input logic [LINKS-1:0]                          outValid,
  input logic [LINKS-1:0]                          outBusy,
  input logic [CORE_IN-1:0]                        inBusy,
  input logic [CORE_IN-1:0][$clog2(FIFO_DEPTH+1)-1:0] fifoCount
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  for (genvar i = 0; i < LINKS; i++) begin : gOutChk
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      cfg.outSel[i] > OSEL_W'(LINKS) |-> !outValid[i] && outData[i*DATA_W +: DATA_W] == '0); // R3
    AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (!rstN)
      cfg.outPipe[i] && cfg.outSel[i] == SEL_CORE && $stable(cfg.outPipe[i]) && $stable(cfg.outSel[i])
      |-> outValid[i] == $past(coreOutValid)); // R4
    AST_OUT_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
      outBusy[i] |=> $stable(cfg.outSel[i]) && $stable(cfg.outPipe[i])); // R8
  end

  for (genvar j = 0; j < CORE_IN; j++) begin : gInChk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      fifoCount[j] <= CW'(FIFO_DEPTH)); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
      fifoCount[j] != $past(fifoCount[j]) |->
        fifoCount[j] == CW'($past(fifoCount[j]) + 1'b1) || fifoCount[j] == CW'($past(fifoCount[j]) - 1'b1)); // R6
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
      cfg.inEn[j] && fifoCount[j] == CW'(FIFO_DEPTH) |-> !inReady[cfg.inSel[j]]); // R7
    AST_IN_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
      inBusy[j] |=> $stable(cfg.inSel[j]) && $stable(cfg.inEn[j])); // R9
  end
endmodule

bind tileRouter tileRouterChk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cfg(cfg), .inReady(inReady),
  .coreOutValid(coreOutValid), .outData(outData), .outValid(outValid),
  .outBusy(outBusy), .inBusy(inBusy), .fifoCount(fifoCount)
);

// File: tb/tileRouter_tb.sv
module tileRouter_tb;
  localparam int L  = 8;
  localparam int DW = 16;
  localparam int NI = 2;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn;
  logic [3:0] cfgAddr;
  logic [4:0] cfgData;
  logic [L*DW-1:0] inData;
  logic [L-1:0] inValid, inReady, outValid;
  logic [DW-1:0] coreOutData;
  logic coreOutValid;
  logic [L*DW-1:0] outData;
  logic [NI-1:0] coreRdEn, coreRdValid;
  logic [NI*DW-1:0] coreRdData;

  int checks = 0;
  int fails = 0;

  // reference model state
  int mSel[L];
  bit mPipe[L];
  bit mPV[L];
  logic [DW-1:0] mPD[L];
  int mInSel[NI];
  bit mInEn[NI];
  logic [DW-1:0] mq[NI][$];

  always #4 clk = ~clk;

  tileRouter u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inData(inData), .inValid(inValid), .inReady(inReady), .coreOutData(coreOutData),
    .coreOutValid(coreOutValid), .outData(outData), .outValid(outValid),
    .coreRdEn(coreRdEn), .coreRdData(coreRdData), .coreRdValid(coreRdValid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic bit srcV(int i);
    if (mSel[i] == 0) return coreOutValid;
    if (mSel[i] >= 1 && mSel[i] <= L) return inValid[mSel[i]-1];
    return 1'b0;
  endfunction

  function automatic logic [DW-1:0] srcD(int i);
    if (mSel[i] == 0) return coreOutData;
    if (mSel[i] >= 1 && mSel[i] <= L) return inData[(mSel[i]-1)*DW +: DW];
    return '0;
  endfunction

  task automatic checkAll();
    for (int i = 0; i < L; i++) begin
      bit ev;
      logic [DW-1:0] ed;
      string tag;
      ev  = mPipe[i] ? mPV[i] : srcV(i);
      ed  = ev ? (mPipe[i] ? mPD[i] : srcD(i)) : '0;
      tag = mPipe[i] ? "R4" : (mSel[i] == 0 ? "R2" : "R3");
      check(tag, 32'(outValid[i]), 32'(ev));
      check(tag, 32'(outData[i*DW +: DW]), 32'(ed));
    end
    for (int k = 0; k < L; k++) begin
      bit er;
      er = 1'b1;
      for (int j = 0; j < NI; j++)
        if (mInEn[j] && mInSel[j] == k && mq[j].size() == DEPTH) er = 1'b0;
      check("R7", 32'(inReady[k]), 32'(er));
    end
    for (int j = 0; j < NI; j++) begin
      check("R6", 32'(coreRdValid[j]), 32'(mq[j].size() > 0));
      if (mq[j].size() > 0) check("R6", 32'(coreRdData[j*DW +: DW]), 32'(mq[j][0]));
    end
  endtask

  task automatic modelUpdate();
    bit nv[L];
    logic [DW-1:0] nd[L];
    bit ob[L];
    bit ib[NI];
    bit pushOk[NI];
    logic [DW-1:0] pd[NI];
    for (int i = 0; i < L; i++) begin
      nv[i] = srcV(i);
      nd[i] = srcD(i);
      ob[i] = nv[i] || (mPipe[i] && mPV[i]);
    end
    for (int j = 0; j < NI; j++) begin
      ib[j] = mInEn[j] && inValid[mInSel[j]];
      pushOk[j] = ib[j] && (mq[j].size() < DEPTH);
      pd[j] = inData[mInSel[j]*DW +: DW];
    end
    for (int j = 0; j < NI; j++) begin
      if (coreRdEn[j] && mq[j].size() > 0) void'(mq[j].pop_front());
      if (pushOk[j]) mq[j].push_back(pd[j]);
    end
    for (int i = 0; i < L; i++) begin
      mPV[i] = nv[i];
      mPD[i] = nd[i];
    end
    if (cfgWrEn) begin
      int a;
      a = int'(cfgAddr);
      if (a < L) begin
        if (!ob[a]) begin
          mSel[a]  = int'(cfgData[3:0]);
          mPipe[a] = cfgData[4];
        end
      end else if (a < L + NI) begin
        if (!ib[a-L]) begin
          mInSel[a-L] = int'(cfgData[2:0]);
          mInEn[a-L]  = cfgData[3];
        end
      end
    end
  endtask

  task automatic tick();
    #1 checkAll();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic idle();
    cfgWrEn = 1'b0; cfgAddr = '0; cfgData = '0;
    inData = '0; inValid = '0; coreOutData = '0; coreOutValid = 1'b0; coreRdEn = '0;
  endtask

  task automatic cfgWrite(int a, int d);
    idle();
    cfgWrEn = 1'b1; cfgAddr = 4'(a); cfgData = 5'(d);
    tick();
    idle();
  endtask

  task automatic randomPhase(int cycles, int validOdds);
    for (int c = 0; c < cycles; c++) begin
      for (int k = 0; k < L; k++) begin
        inValid[k] = ($urandom_range(0, validOdds - 1) == 0);
        inData[k*DW +: DW] = 16'($urandom);
      end
      coreOutValid = ($urandom_range(0, validOdds - 1) == 0);
      coreOutData  = 16'($urandom);
      for (int j = 0; j < NI; j++) coreRdEn[j] = ($urandom_range(0, 3) == 0);
      cfgWrEn = ($urandom_range(0, 7) == 0);
      cfgAddr = 4'($urandom_range(0, 15));
      cfgData = 5'($urandom);
      tick();
    end
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < L; i++) begin
      mSel[i] = 15; mPipe[i] = 0; mPV[i] = 0; mPD[i] = '0;
    end
    for (int j = 0; j < NI; j++) begin
      mInSel[j] = 0; mInEn[j] = 0;
    end
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1", 32'(outValid), 32'h0);
    check("R1", 32'(outData == '0), 32'h1);
    check("R1", 32'(coreRdValid), 32'h0);
    check("R1", 32'(inReady), 32'hFF);
    tick();

    // routes: out0 core, out1 link2, out2 link4 piped, out3 disabled
    cfgWrite(0, 0);
    cfgWrite(1, 3);
    cfgWrite(2, 5'h10 | 5);
    cfgWrite(3, 9);
    inValid[2] = 1'b1; inData[2*DW +: DW] = 16'hA5A5;
    inValid[4] = 1'b1; inData[4*DW +: DW] = 16'h5A5A;
    inValid[8-1] = 1'b1; inData[7*DW +: DW] = 16'h0F0F;
    coreOutValid = 1'b1; coreOutData = 16'h1234;
    #1;
    check("R3", 32'(outData[1*DW +: DW]), 32'hA5A5);
    check("R2", 32'(outData[0*DW +: DW]), 32'h1234);
    check("R4", 32'(outValid[2]), 32'h0);
    check("R3", 32'(outValid[3]), 32'h0);
    tick();
    idle();
    #1;
    check("R4", 32'(outValid[2]), 32'h1);
    check("R4", 32'(outData[2*DW +: DW]), 32'h5A5A);
    tick();

    // R8: write to out1 while its link is valid is dropped
    inValid[2] = 1'b1; inData[2*DW +: DW] = 16'h1111;
    cfgWrEn = 1'b1; cfgAddr = 4'd1; cfgData = 5'd0;
    tick();
    idle();
    coreOutValid = 1'b1; coreOutData = 16'h7777;
    #1 check("R8", 32'(outValid[1]), 32'h0);
    tick();
    cfgWrite(1, 0);
    coreOutValid = 1'b1; coreOutData = 16'h7777;
    #1 check("R2", 32'(outData[1*DW +: DW]), 32'h7777);
    tick();
    idle();

    // R8: pipeline stage holding a word also blocks the write
    inValid[4] = 1'b1; inData[4*DW +: DW] = 16'h2222;
    tick();
    idle();
    cfgWrEn = 1'b1; cfgAddr = 4'd2; cfgData = 5'd0;
    tick();
    idle();
    coreOutValid = 1'b1; coreOutData = 16'h4321;
    #1 check("R8", 32'(outValid[2]), 32'h0);
    tick();
    idle();

    // R5 R6 R7: fill core input 0 from link1
    cfgWrite(8, 8 | 1);
    for (int n = 0; n < 70; n++) begin
      inValid[1] = 1'b1; inData[1*DW +: DW] = 16'(n);
      if (n == 0) #1 check("R6", 32'(coreRdValid[0]), 32'h0);
      if (n == 64) begin
        #1;
        check("R7", 32'(inReady[1]), 32'h0);
        check("R7", 32'(inReady[0]), 32'h1);
      end
      tick();
    end
    idle();
    #1;
    check("R5", 32'(coreRdValid[0]), 32'h1);
    check("R6", 32'(coreRdData[0 +: DW]), 32'h0);
    for (int r = 0; r < 64; r++) begin
      coreRdEn[0] = 1'b1;
      tick();
    end
    idle();
    #1 check("R6", 32'(coreRdValid[0]), 32'h0);

    // R5: disabled input stores nothing
    cfgWrite(8, 0);
    inValid[1] = 1'b1; inData[1*DW +: DW] = 16'h3333;
    tick();
    idle();
    #1 check("R5", 32'(coreRdValid[0]), 32'h0);

    // R9: core input reselect blocked while its link is valid
    cfgWrite(9, 8 | 6);
    inValid[6] = 1'b1; inData[6*DW +: DW] = 16'h6666;
    cfgWrEn = 1'b1; cfgAddr = 4'd9; cfgData = 5'(8 | 0);
    tick();
    idle();
    inValid[0] = 1'b1; inData[0 +: DW] = 16'hBEEF;
    #1;
    check("R9", 32'(coreRdValid[1]), 32'h1);
    check("R9", 32'(coreRdData[DW +: DW]), 32'h6666);
    tick();
    idle();
    coreRdEn[1] = 1'b1;
    tick();
    idle();
    #1 check("R9", 32'(coreRdValid[1]), 32'h0);

    // mixed random traffic and configuration
    randomPhase(2000, 2);
    randomPhase(2000, 5);
    tick();
    finishRun();
  end
endmodule